// File: doc/BRIEF.md
# Paged EEPROM Write Controller with Keyed Protection

This block sits on the write path of an on-chip EEPROM array and turns single-byte writes from a parallel address/data port into page programming cycles. Bytes that share one page (all address bits above the in-page offset) collect in a page buffer together with a per-byte valid mask. When no write has arrived for a set number of cycles, or when a write names a different page, the collected page is handed out as a one-cycle commit request. A timed write cycle follows, and the block shows itself busy for its full length.

A software write-protect bit guards the array. While it is set, a data write is taken only if a three-write unlock key comes just before it. The same key sets the bit when it is clear. A six-write key clears the bit. Every change of the bit takes a full write cycle and lands when that cycle ends. The bit's stored value is an input sampled at reset, so the non-volatile copy can live outside the block. After reset, writes are inhibited for a power-up interval. The write cycle length, the inter-write timeout and the power-up interval are all cycle-count parameters.

Top module: `eep_page_ctl`

## Requirements
- R1: From reset, `ready` is low and every write is ignored for `T_PWRUP` cycles; `ready` then rises. `prot_state` takes the value of `prot_nv_in` sampled during reset.
- R2: When the block is ready and unprotected, a write that is not part of a key is accepted, and `ready` is low from the next clock edge.
- R3: An accepted byte is stored at the offset given by `wr_addr[5:0]` and its mask bit is set. A later byte at the same offset overwrites it. `commit_page` carries `wr_addr[14:6]` of the page.
- R4: `T_GAP` edges after the last accepted write, `commit_valid` is high for exactly one cycle and carries the page, the data and the mask.
- R5: During collection, a write to a page other than the one being collected closes the page at once (commit on that edge), and that write is dropped.
- R6: The write cycle lasts `T_WC` cycles after the commit edge. Writes during it are ignored, and `ready` rises when it ends.
- R7: When the block is protected, a write that is not a key write is ignored: `ready` stays high and no commit follows.
- R8: The enable key, written in order as AAh@5555h, 55h@2AAAh, A0h@5555h, opens a collection in which writes are accepted, with or without protection. Key bytes are never stored. `prot_state` is 1 once the following write cycle ends.
- R9: The disable key, written in order as AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h, starts a write cycle on its last edge. `prot_state` drops to 0 when that cycle ends.
- R10: A write that breaks a key sequence restarts key matching. AAh@5555h counts as a new first step. Any other breaking write is handled as an ordinary data write.
- R11: A collection that ends with no byte stored still runs a write cycle, but `commit_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| prot_nv_in | input | 1 | Stored protect bit, loaded during reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_addr | input | 15 | Write address; bits 5:0 select the byte in the page |
| wr_data | input | 8 | Write data |
| ready | output | 1 | High when idle; low during power-up, collection and write cycle |
| prot_state | output | 1 | Current protect bit |
| commit_valid | output | 1 | One-cycle page commit request |
| commit_page | output | 9 | Page number of the commit |
| commit_data | output | 512 | Page bytes; byte i at bits 8*i+7:8*i |
| commit_mask | output | 64 | Bit i set when byte i was written |

## Verification
An accepted write lowers `ready` on the same edge that samples it. A commit appears `T_GAP` edges after the last accepted write, or on the edge of a page-switching write. `ready` and `prot_state` change together `T_WC` edges after the write cycle begins, and power-up release comes `T_PWRUP` edges after reset. A behavioural model in the bench advances on the same rising edge as the design, and all outputs are compared at the following falling edge, so each result is checked in the cycle it is due and the check does not depend on the order of processes. Directed checks read `ready` right after the stimulus edge and count commits over each scenario.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_INIT,
        ST_IDLE,
        ST_OPEN,
        ST_PROG
    } eep_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } eep_wr_t;

    localparam logic [ADDR_W-1:0] KEY_ADR_A = 15'h5555;
    localparam logic [ADDR_W-1:0] KEY_ADR_B = 15'h2AAA;
    localparam logic [DATA_W-1:0] KEY_LEAD  = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_SECND = 8'h55;
    localparam logic [DATA_W-1:0] KEY_SETP  = 8'hA0;
    localparam logic [DATA_W-1:0] KEY_CLRA  = 8'h80;
    localparam logic [DATA_W-1:0] KEY_CLRB  = 8'h20;

    // Expected write at each step of the long (clearing) key.
    function automatic eep_wr_t key_word(input logic [2:0] step);
        eep_wr_t w;
        case (step)
            3'd0, 3'd3: w = '{addr: KEY_ADR_A, data: KEY_LEAD};
            3'd1, 3'd4: w = '{addr: KEY_ADR_B, data: KEY_SECND};
            3'd2:       w = '{addr: KEY_ADR_A, data: KEY_CLRA};
            default:    w = '{addr: KEY_ADR_A, data: KEY_CLRB};
        endcase
        return w;
    endfunction

    function automatic logic same_wr(input eep_wr_t a, input eep_wr_t b);
        return (a.addr == b.addr) && (a.data == b.data);
    endfunction

endpackage

// File: rtl/eep_key_seq.sv
module eep_key_seq
    import eep_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_valid,
    input  eep_wr_t wr,
    output logic    take,
    output logic    en_hit,
    output logic    dis_hit
);

    logic [2:0] step_q;
    logic [2:0] step_d;

    always_comb begin
        take    = 1'b0;
        en_hit  = 1'b0;
        dis_hit = 1'b0;
        step_d  = step_q;
        if (wr_valid) begin
            if (step_q == 3'd2 && same_wr(wr, '{addr: KEY_ADR_A, data: KEY_SETP})) begin
                take   = 1'b1;
                en_hit = 1'b1;
                step_d = 3'd0;
            end else if (same_wr(wr, key_word(step_q))) begin
                take = 1'b1;
                if (step_q == 3'd5) begin
                    dis_hit = 1'b1;
                    step_d  = 3'd0;
                end else begin
                    step_d = step_q + 3'd1;
                end
            end else if (same_wr(wr, '{addr: KEY_ADR_A, data: KEY_LEAD})) begin
                take   = 1'b1;
                step_d = 3'd1;
            end else begin
                step_d = 3'd0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= 3'd0;
        else     step_q <= step_d;
    end

endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf
    import eep_pkg::*;
#(
    parameter int PAGE_BYTES = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  logic                         load,
    input  eep_wr_t                      wr,
    output logic [PAGE_BYTES*DATA_W-1:0] data_flat,
    output logic [PAGE_BYTES-1:0]        mask
);

    localparam int OFS_W = $clog2(PAGE_BYTES);

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
        logic [DATA_W-1:0] byte_q;
        logic              vld_q;
        logic              hit;

        assign hit = load && (wr.addr[OFS_W-1:0] == OFS_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q <= '0;
                vld_q  <= 1'b0;
            end else begin
                if (clear) vld_q <= 1'b0;
                if (hit) begin
                    byte_q <= wr.data;
                    vld_q  <= 1'b1;
                end
            end
        end

        assign data_flat[g*DATA_W +: DATA_W] = byte_q;
        assign mask[g] = vld_q;
    end

endmodule

// File: rtl/eep_page_ctl.sv
module eep_page_ctl
    import eep_pkg::*;
#(
    parameter int PAGE_BYTES = 64,
    parameter int T_GAP      = 8,
    parameter int T_WC       = 24,
    parameter int T_PWRUP    = 16
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      prot_nv_in,
    input  logic                                      wr_en,
    input  logic [14:0]                               wr_addr,
    input  logic [7:0]                                wr_data,
    output logic                                      ready,
    output logic                                      prot_state,
    output logic                                      commit_valid,
    output logic [14-$clog2(PAGE_BYTES):0]            commit_page,
    output logic [PAGE_BYTES*8-1:0]                   commit_data,
    output logic [PAGE_BYTES-1:0]                     commit_mask
);

    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam int MAXT_A = (T_WC > T_GAP) ? T_WC : T_GAP;
    localparam int MAXT   = (MAXT_A > T_PWRUP) ? MAXT_A : T_PWRUP;
    localparam int CNT_W  = $clog2(MAXT + 1);
    localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(T_GAP - 1);
    localparam logic [CNT_W-1:0] WC_LAST   = CNT_W'(T_WC - 1);
    localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(T_PWRUP - 1);

    eep_state_e        state;
    logic [CNT_W-1:0]  tick;
    logic [PAGE_W-1:0] cur_page;
    logic              prot_q, set_pend, clr_pend, cv_q;
    eep_wr_t           wr_pkt;
    logic [PAGE_W-1:0] page_in;
    logic              key_take, en_hit, dis_hit;
    logic              acc_idle, acc_open, split, gap_end, has_bytes;
    logic [PAGE_BYTES-1:0] buf_mask;

    assign wr_pkt  = '{addr: wr_addr, data: wr_data};
    assign page_in = wr_addr[ADDR_W-1:OFS_W];

    eep_key_seq u_key (
        .clk     (clk),
        .rst     (rst),
        .wr_valid(wr_en && state == ST_IDLE),
        .wr      (wr_pkt),
        .take    (key_take),
        .en_hit  (en_hit),
        .dis_hit (dis_hit)
    );

    assign has_bytes = |buf_mask;
    assign acc_idle  = wr_en && state == ST_IDLE && !key_take && !prot_q;
    assign split     = wr_en && state == ST_OPEN && has_bytes && page_in != cur_page;
    assign acc_open  = wr_en && state == ST_OPEN && !split;
    assign gap_end   = !wr_en && state == ST_OPEN && tick == GAP_LAST;

    eep_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .clear    (acc_idle || en_hit),
        .load     (acc_idle || acc_open),
        .wr       (wr_pkt),
        .data_flat(commit_data),
        .mask     (buf_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_INIT;
            tick     <= '0;
            cur_page <= '0;
            prot_q   <= prot_nv_in;
            set_pend <= 1'b0;
            clr_pend <= 1'b0;
            cv_q     <= 1'b0;
        end else begin
            cv_q <= 1'b0;
            case (state)
                ST_INIT: begin
                    if (tick == INIT_LAST) begin
                        state <= ST_IDLE;
                        tick  <= '0;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                ST_IDLE: begin
                    tick <= '0;
                    if (en_hit) begin
                        state    <= ST_OPEN;
                        set_pend <= 1'b1;
                    end else if (dis_hit) begin
                        state    <= ST_PROG;
                        clr_pend <= 1'b1;
                    end else if (acc_idle) begin
                        state    <= ST_OPEN;
                        cur_page <= page_in;
                    end
                end
                ST_OPEN: begin
                    if (split || gap_end) begin
                        state <= ST_PROG;
                        tick  <= '0;
                        cv_q  <= has_bytes;
                    end else if (wr_en) begin
                        tick <= '0;
                        if (!has_bytes) cur_page <= page_in;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                default: begin
                    if (tick == WC_LAST) begin
                        state    <= ST_IDLE;
                        tick     <= '0;
                        set_pend <= 1'b0;
                        clr_pend <= 1'b0;
                        if (set_pend) prot_q <= 1'b1;
                        if (clr_pend) prot_q <= 1'b0;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
            endcase
        end
    end

    assign ready        = (state == ST_IDLE);
    assign prot_state   = prot_q;
    assign commit_valid = cv_q;
    assign commit_page  = cur_page;
    assign commit_mask  = buf_mask;

endmodule

// File: rtl/eep_page_ctl_chk.sv
module eep_page_ctl_chk #(
    parameter int T_PWRUP    = 16,
    parameter int PAGE_BYTES = 64
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  ready,
    input logic                  prot_state,
    input logic                  commit_valid,
    input logic [PAGE_BYTES-1:0] commit_mask
);

    localparam int SW = $clog2(T_PWRUP + 1);
    logic [SW-1:0] since;

    always_ff @(posedge clk) begin
        if (rst)                      since <= '0;
        else if (since != SW'(T_PWRUP)) since <= since + 1'b1;
    end

    // R1: held busy through the power-up interval
    a_r1_init_busy: assert property (@(posedge clk) disable iff (rst)
        (since < SW'(T_PWRUP)) |-> !ready);

    // R1: released right at the end of the interval
    a_r1_init_release: assert property (@(posedge clk) disable iff (rst)
        (since == SW'(T_PWRUP)) && $past(since != SW'(T_PWRUP)) |-> ready);

    // R4: commit request lasts one cycle
    a_r4_commit_single: assert property (@(posedge clk) disable iff (rst)
        commit_valid |=> !commit_valid);

    // R11: no commit without a stored byte
    a_r11_commit_has_bytes: assert property (@(posedge clk) disable iff (rst)
        commit_valid |-> (|commit_mask));

    // R6: busy while the commit is presented and the cycle after
    a_r6_busy_in_cycle: assert property (@(posedge clk) disable iff (rst)
        commit_valid |-> !ready ##1 !ready);

    // R9: protect bit only moves when a write cycle ends
    a_r9_prot_moves_at_end: assert property (@(posedge clk) disable iff (rst)
        !$stable(prot_state) |-> $rose(ready));

endmodule

bind eep_page_ctl eep_page_ctl_chk #(
    .T_PWRUP   (T_PWRUP),
    .PAGE_BYTES(PAGE_BYTES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ready       (ready),
    .prot_state  (prot_state),
    .commit_valid(commit_valid),
    .commit_mask (commit_mask)
);

// File: tb/eep_page_ctl_tb.sv
module eep_page_ctl_tb;

    localparam int PB = 64;
    localparam int TG = 8;
    localparam int TW = 24;
    localparam int TP = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          prot_nv_in = 1'b0;
    logic          wr_en = 1'b0;
    logic [14:0]   wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          ready, prot_state, commit_valid;
    logic [8:0]    commit_page;
    logic [PB*8-1:0] commit_data;
    logic [PB-1:0] commit_mask;

    eep_page_ctl #(.PAGE_BYTES(PB), .T_GAP(TG), .T_WC(TW), .T_PWRUP(TP)) u_dut (
        .clk(clk), .rst(rst), .prot_nv_in(prot_nv_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ready(ready),
        .prot_state(prot_state), .commit_valid(commit_valid),
        .commit_page(commit_page), .commit_data(commit_data),
        .commit_mask(commit_mask)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int n_commit = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int       k_addr [6] = '{'h5555, 'h2AAA, 'h5555, 'h5555, 'h2AAA, 'h5555};
    int       k_data [6] = '{'hAA, 'h55, 'h80, 'hAA, 'h55, 'h20};
    int       m_mode;          // 0 power-up, 1 idle, 2 collecting, 3 write cycle
    int       m_cnt, m_step, m_page;
    bit       m_prot, m_pset, m_pclr, m_cv;
    bit [7:0] m_data [PB];
    bit       m_mask [PB];

    function automatic bit m_any();
        for (int i = 0; i < PB; i++) if (m_mask[i]) return 1;
        return 0;
    endfunction

    task automatic m_fresh();
        for (int i = 0; i < PB; i++) m_mask[i] = 0;
        m_mode = 2;
        m_cnt  = 0;
    endtask

    task automatic m_store(input int a, input int d);
        m_data[a % PB] = d[7:0];
        m_mask[a % PB] = 1;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_cnt = 0; m_step = 0; m_page = 0;
            m_prot = prot_nv_in; m_pset = 0; m_pclr = 0; m_cv = 0;
            for (int i = 0; i < PB; i++) m_mask[i] = 0;
        end else begin
            int a, d;
            a = int'(wr_addr);
            d = int'(wr_data);
            m_cv = 0;
            case (m_mode)
                0: begin
                    m_cnt++;
                    if (m_cnt == TP) begin m_mode = 1; m_cnt = 0; end
                end
                1: if (wr_en) begin
                    if (m_step == 2 && a == 'h5555 && d == 'hA0) begin
                        m_step = 0; m_fresh(); m_pset = 1;
                    end else if (a == k_addr[m_step] && d == k_data[m_step]) begin
                        m_step++;
                        if (m_step == 6) begin
                            m_step = 0; m_mode = 3; m_cnt = 0; m_pclr = 1;
                        end
                    end else if (a == 'h5555 && d == 'hAA) begin
                        m_step = 1;
                    end else begin
                        m_step = 0;
                        if (!m_prot) begin
                            m_fresh(); m_page = a / PB; m_store(a, d);
                        end
                    end
                end
                2: begin
                    if (wr_en) begin
                        if (m_any() && (a / PB) != m_page) begin
                            m_mode = 3; m_cnt = 0; m_cv = 1;
                        end else begin
                            if (!m_any()) m_page = a / PB;
                            m_store(a, d);
                            m_cnt = 0;
                        end
                    end else begin
                        m_cnt++;
                        if (m_cnt == TG) begin
                            m_cv = m_any(); m_mode = 3; m_cnt = 0;
                        end
                    end
                end
                default: begin
                    m_cnt++;
                    if (m_cnt == TW) begin
                        m_mode = 1; m_cnt = 0;
                        if (m_pset) m_prot = 1;
                        if (m_pclr) m_prot = 0;
                        m_pset = 0; m_pclr = 0;
                    end
                end
            endcase
        end
    end

    // Compare every cycle, away from the rising edge.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(ready == (m_mode == 1), "R6", "ready", 64'(ready), 64'(m_mode == 1));
            chk(prot_state == m_prot, "R8", "prot_state", 64'(prot_state), 64'(m_prot));
            chk(commit_valid == m_cv, "R4", "commit_valid", 64'(commit_valid), 64'(m_cv));
            if (commit_valid) n_commit++;
            if (commit_valid && m_cv) begin
                chk(int'(commit_page) == m_page, "R3", "commit_page",
                    64'(commit_page), 64'(m_page));
                for (int i = 0; i < PB; i++) begin
                    chk(commit_mask[i] == m_mask[i], "R3", "mask bit",
                        64'(commit_mask[i]), 64'(m_mask[i]));
                    if (m_mask[i])
                        chk(commit_data[i*8 +: 8] == m_data[i], "R3", "data byte",
                            64'(commit_data[i*8 +: 8]), 64'(m_data[i]));
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_reset(input bit nv);
        @(negedge clk);
        rst = 1'b1; prot_nv_in = nv; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr_b(input logic [14:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 400; i++) begin
            if (ready && m_mode == 1) return;
            @(negedge clk);
        end
    endtask

    task automatic key_en();
        wr_b(15'h5555, 8'hAA); wr_b(15'h2AAA, 8'h55); wr_b(15'h5555, 8'hA0);
    endtask

    int c0;

    initial begin
        do_reset(1'b0);
        // R1: writes during power-up are ignored
        wr_b(15'h0040, 8'h5A);
        chk(ready == 1'b0, "R1", "ready in power-up", 64'(ready), 64'd0);
        chk(prot_state == 1'b0, "R1", "prot after reset", 64'(prot_state), 64'd0);
        wait_ready();
        chk(n_commit == 0, "R1", "commits in power-up", 64'(n_commit), 64'd0);

        // R2/R3/R4: collect three bytes with one overwrite
        c0 = n_commit;
        wr_b(15'h0083, 8'h11);
        chk(ready == 1'b0, "R2", "ready after accept", 64'(ready), 64'd0);
        wr_b(15'h0085, 8'h22);
        idle_n(3);
        wr_b(15'h0083, 8'h33);
        wr_b(15'h00BF, 8'h44);
        wait_ready();
        chk(n_commit - c0 == 1, "R4", "commit count", 64'(n_commit - c0), 64'd1);

        // R5: page switch closes the page, switching write dropped
        c0 = n_commit;
        wr_b(15'h00C1, 8'h55);
        wr_b(15'h00C2, 8'h66);
        wr_b(15'h0100, 8'h77);
        chk(ready == 1'b0, "R5", "busy after switch", 64'(ready), 64'd0);
        wait_ready();
        chk(n_commit - c0 == 1, "R5", "commit count", 64'(n_commit - c0), 64'd1);

        // R10: broken key, breaking write becomes data
        c0 = n_commit;
        wr_b(15'h5555, 8'hAA);
        chk(ready == 1'b1, "R10", "key step idle", 64'(ready), 64'd1);
        wr_b(15'h0105, 8'h99);
        chk(ready == 1'b0, "R10", "break taken as data", 64'(ready), 64'd0);
        wait_ready();
        chk(n_commit - c0 == 1, "R10", "commit count", 64'(n_commit - c0), 64'd1);

        // R8: enable key then data, protection set afterwards
        c0 = n_commit;
        key_en();
        wr_b(15'h0200, 8'hA1);
        wr_b(15'h0201, 8'hA2);
        wait_ready();
        chk(prot_state == 1'b1, "R8", "prot set", 64'(prot_state), 64'd1);
        chk(n_commit - c0 == 1, "R8", "commit count", 64'(n_commit - c0), 64'd1);

        // R7: protected plain write ignored
        c0 = n_commit;
        wr_b(15'h0300, 8'hEE);
        chk(ready == 1'b1, "R7", "ready stays", 64'(ready), 64'd1);
        idle_n(TG + 4);
        chk(n_commit - c0 == 0, "R7", "commit count", 64'(n_commit - c0), 64'd0);

        // R8: keyed write while protected, protection stays
        c0 = n_commit;
        key_en();
        wr_b(15'h0310, 8'hB7);
        wait_ready();
        chk(n_commit - c0 == 1, "R8", "keyed commit", 64'(n_commit - c0), 64'd1);
        chk(prot_state == 1'b1, "R8", "prot kept", 64'(prot_state), 64'd1);

        // R11: key with no data runs a cycle, no commit
        c0 = n_commit;
        key_en();
        chk(ready == 1'b0, "R11", "busy after key", 64'(ready), 64'd0);
        wait_ready();
        chk(n_commit - c0 == 0, "R11", "commit count", 64'(n_commit - c0), 64'd0);

        // R9: disable key
        wr_b(15'h5555, 8'hAA); wr_b(15'h2AAA, 8'h55); wr_b(15'h5555, 8'h80);
        wr_b(15'h5555, 8'hAA); wr_b(15'h2AAA, 8'h55); wr_b(15'h5555, 8'h20);
        chk(ready == 1'b0, "R9", "busy after clear key", 64'(ready), 64'd0);
        chk(prot_state == 1'b1, "R9", "prot before end", 64'(prot_state), 64'd1);
        wait_ready();
        chk(prot_state == 1'b0, "R9", "prot cleared", 64'(prot_state), 64'd0);

        // R6: write during the write cycle is ignored
        c0 = n_commit;
        wr_b(15'h0400, 8'h12);
        idle_n(TG + 3);
        wr_b(15'h0401, 8'h34);
        chk(ready == 1'b0, "R6", "still busy", 64'(ready), 64'd0);
        wait_ready();
        chk(n_commit - c0 == 1, "R6", "commit count", 64'(n_commit - c0), 64'd1);
        idle_n(TG + 4);
        chk(n_commit - c0 == 1, "R6", "no late commit", 64'(n_commit - c0), 64'd1);

        // R1: stored protect value restored by reset
        do_reset(1'b1);
        @(negedge clk);
        chk(prot_state == 1'b1, "R1", "prot from store", 64'(prot_state), 64'd1);
        chk(ready == 1'b0, "R1", "busy after reset", 64'(ready), 64'd0);
        wait_ready();

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule